// File: doc/BRIEF.md
# DMA Bus Arbiter with Priority Levels and Bandwidth Fairness

This block picks one owner for a shared bus out of a CPU request and a parameterised set of DMA channel requests (24 by default). Each channel comes with a 3-bit priority level and a round-robin enable bit. A global switch turns bandwidth fairness on or off. The arbiter registers a one-hot grant and keeps it until the owner signals the end of its transaction. It then arbitrates again in that same cycle. A more urgent request can therefore take over only at a transaction boundary.

The CPU normally wins. A quota counter stops it from starving DMA. Among DMA channels the lowest level number wins. When fairness is on, levels 2 to 7 draw on per-level credit counters whose weights halve from level to level. A level with no credit left steps aside while another requesting level still has credit. Levels 0 and 1 never draw on credit. Ties inside a level go to a head-of-line channel (one with round-robin off) if there is one. Otherwise they go to the next round-robin channel after the last one served at that level.

Top module: `dma_bus_arbiter`

## Requirements
- R1: At most one of `grant_cpu` and the bits of `grant_ch` is high in any cycle.
- R2: Arbitration happens only when the bus is free (`busy` low) or `xfer_done` is high. The new grant appears in the cycle after that edge. While `busy` is high and `xfer_done` is low, the grant does not change.
- R3: At an arbitration point, a CPU request wins over every DMA request unless the CPU quota is reached.
- R4: After CPU_MAX consecutive CPU grants, if any channel requests, the next grant goes to a DMA channel. Any DMA grant clears the CPU count.
- R5: With `fair_en` low, the requesting channel with the lowest level wins. The level of channel c is `ch_level[3c+2:3c]`, and 0 is the most urgent.
- R6: Levels 0 and 1 win over levels 2 to 7 whatever the credits hold, and grants at levels 0 and 1 consume no credit.
- R7: With `fair_en` high, the weight of level L (2..7) is max(1, BASE_CREDIT >> (L-2)). Each grant at L consumes one credit. A level with zero credit is passed over while another requesting level has credit. Credits start full after reset.
- R8: When every requesting level is a fair level with zero credit, all credits refill to their weights. The lowest requesting level wins and consumes one credit.
- R9: Among requesting round-robin channels at the winning level, the first one after the last round-robin channel granted at that level wins. The search wraps around. After reset, channel 0 is searched first.
- R10: A requesting channel with `ch_rr_en` low at the winning level wins over that level's round-robin channels. The lowest index wins among several such channels.
- R11: A more urgent request that arrives mid-transaction takes the bus only after `xfer_done`.
- R12: After reset, no grant is asserted and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fair_en | input | 1 | Enables credit-based fairness for levels 2..7 |
| cpu_req | input | 1 | CPU requests the bus |
| ch_req | input | NUM_CH | Per-channel DMA request |
| ch_level | input | 3*NUM_CH | Per-channel priority level, 3 bits per channel |
| ch_rr_en | input | NUM_CH | Per-channel round-robin enable (low = head of line) |
| xfer_done | input | 1 | Current owner finishes its transaction this cycle |
| grant_cpu | output | 1 | CPU owns the bus |
| grant_ch | output | NUM_CH | One-hot DMA channel grant |
| busy | output | 1 | A grant is held |

## Verification
The bench holds a grant and raises a level-0 request mid-transaction. A design that re-arbitrates on every cycle would switch owners before `xfer_done`. It runs the CPU into its quota with a channel waiting. A missing or off-by-one quota either starves the channel or hands it the bus one grant early or late. It drives two fair levels against each other across a refill, tracking the credits in its own model. A design that never refills, or that charges grants at levels 0 and 1, drifts from the expected grant order. The round-robin rotation, its wrap and a head-of-line channel are also checked. A pointer that does not advance, or that ignores `ch_rr_en`, repeats the wrong channel.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int LVL_W      = 3;
  localparam int NUM_LVL    = 1 << LVL_W;
  localparam int FAIR_FIRST = 2;

  // Credit weight of a fair level: halves per level, never below one.
  function automatic int level_weight(input int lvl, input int base);
    int w;
    if (lvl < FAIR_FIRST) return 0;
    w = base >> (lvl - FAIR_FIRST);
    if (w < 1) w = 1;
    return w;
  endfunction

  // Index of the lowest set bit of a level vector (0 if none).
  function automatic logic [LVL_W-1:0] lowest_level(input logic [NUM_LVL-1:0] v);
    logic [LVL_W-1:0] r;
    r = '0;
    for (int i = NUM_LVL - 1; i >= 0; i--) begin
      if (v[i]) r = LVL_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/dma_fair_credit.sv
module dma_fair_credit
  import dma_arb_pkg::*;
#(
  parameter int BASE_CREDIT = 32,
  localparam int CR_W = $clog2(BASE_CREDIT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               consume,
  input  logic [LVL_W-1:0]   cons_lvl,
  input  logic               refill,
  output logic [NUM_LVL-1:0] credit_ok
);
  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    if (l < FAIR_FIRST) begin : g_exempt
      assign credit_ok[l] = 1'b1;
    end else begin : g_fair
      localparam logic [CR_W-1:0] WEIGHT = CR_W'(level_weight(l, BASE_CREDIT));
      logic [CR_W-1:0] credit_q;
      wire hit = (cons_lvl == LVL_W'(l));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          credit_q <= WEIGHT;
        end else if (consume) begin
          if (refill) begin
            credit_q <= hit ? WEIGHT - CR_W'(1) : WEIGHT;
          end else if (hit && credit_q != '0) begin
            credit_q <= credit_q - CR_W'(1);
          end
        end
      end
      assign credit_ok[l] = (credit_q != '0);
    end
  end
endmodule

// File: rtl/dma_level_select.sv
module dma_level_select
  import dma_arb_pkg::*;
(
  input  logic [NUM_LVL-1:0] lvl_req,
  input  logic [NUM_LVL-1:0] credit_ok,
  input  logic               fair_en,
  output logic [LVL_W-1:0]   win_lvl,
  output logic               refill
);
  logic [NUM_LVL-1:0] eligible;

  always_comb begin
    eligible = lvl_req & credit_ok;
    refill   = 1'b0;
    if (!fair_en) begin
      win_lvl = lowest_level(lvl_req);
    end else if (eligible != '0) begin
      win_lvl = lowest_level(eligible);
    end else begin
      win_lvl = lowest_level(lvl_req);
      refill  = (lvl_req != '0);
    end
  end
endmodule

// File: rtl/dma_chan_pick.sv
module dma_chan_pick #(
  parameter int NUM_CH = 24,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] cand,
  input  logic [NUM_CH-1:0] rr_en,
  input  logic [CH_W-1:0]   last_idx,
  output logic [CH_W-1:0]   win_idx,
  output logic              win_is_rr
);
  logic [NUM_CH-1:0] head;
  logic              found;
  int                idx;

  always_comb begin
    head      = cand & ~rr_en;
    win_idx   = '0;
    win_is_rr = 1'b0;
    found     = 1'b0;
    idx       = 0;
    if (head != '0) begin
      for (int i = NUM_CH - 1; i >= 0; i--) begin
        if (head[i]) win_idx = CH_W'(i);
      end
    end else begin
      for (int k = 1; k <= NUM_CH; k++) begin
        idx = int'(last_idx) + k;
        if (idx >= NUM_CH) idx = idx - NUM_CH;
        if (!found && cand[idx]) begin
          win_idx   = CH_W'(idx);
          win_is_rr = 1'b1;
          found     = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH      = 24,
  parameter int BASE_CREDIT = 32,
  parameter int CPU_MAX     = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fair_en,
  input  logic                    cpu_req,
  input  logic [NUM_CH-1:0]       ch_req,
  input  logic [LVL_W*NUM_CH-1:0] ch_level,
  input  logic [NUM_CH-1:0]       ch_rr_en,
  input  logic                    xfer_done,
  output logic                    grant_cpu,
  output logic [NUM_CH-1:0]       grant_ch,
  output logic                    busy
);
  localparam int CH_W = $clog2(NUM_CH);
  localparam int ST_W = $clog2(CPU_MAX + 1);

  logic [NUM_LVL-1:0][NUM_CH-1:0] lvl_hit;
  logic [NUM_LVL-1:0]             lvl_req;
  logic [NUM_LVL-1:0]             credit_ok;
  logic [LVL_W-1:0]               win_lvl;
  logic                           refill_evt;
  logic [CH_W-1:0]                win_idx;
  logic                           win_is_rr;
  logic [CH_W-1:0]                rr_last [NUM_LVL];
  logic [ST_W-1:0]                cpu_streak;
  logic                           grant_cpu_q;
  logic [NUM_CH-1:0]              grant_ch_q;
  logic                           busy_q;

  // Named internal events for the checker.
  logic arb_open, any_dma, cpu_quota_hit, pick_cpu, cpu_fire, dma_fire;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign lvl_hit[l][c] = (ch_level[LVL_W*c +: LVL_W] == LVL_W'(l));
    end
    assign lvl_req[l] = |(ch_req & lvl_hit[l]);
  end

  dma_level_select u_lvl (
    .lvl_req  (lvl_req),
    .credit_ok(credit_ok),
    .fair_en  (fair_en),
    .win_lvl  (win_lvl),
    .refill   (refill_evt)
  );

  dma_chan_pick #(.NUM_CH(NUM_CH)) u_pick (
    .cand     (ch_req & lvl_hit[win_lvl]),
    .rr_en    (ch_rr_en),
    .last_idx (rr_last[win_lvl]),
    .win_idx  (win_idx),
    .win_is_rr(win_is_rr)
  );

  dma_fair_credit #(.BASE_CREDIT(BASE_CREDIT)) u_credit (
    .clk      (clk),
    .rst_n    (rst_n),
    .consume  (dma_fire && fair_en),
    .cons_lvl (win_lvl),
    .refill   (refill_evt),
    .credit_ok(credit_ok)
  );

  assign arb_open      = !busy_q || xfer_done;
  assign any_dma       = |ch_req;
  assign cpu_quota_hit = (cpu_streak >= ST_W'(CPU_MAX));
  assign pick_cpu      = cpu_req && !(cpu_quota_hit && any_dma);
  assign cpu_fire      = arb_open && pick_cpu;
  assign dma_fire      = arb_open && !pick_cpu && any_dma;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_cpu_q <= 1'b0;
      grant_ch_q  <= '0;
      busy_q      <= 1'b0;
    end else if (arb_open) begin
      grant_cpu_q <= cpu_fire;
      grant_ch_q  <= dma_fire ? (NUM_CH'(1) << win_idx) : '0;
      busy_q      <= cpu_fire || dma_fire;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_streak <= '0;
    end else if (dma_fire) begin
      cpu_streak <= '0;
    end else if (cpu_fire && !cpu_quota_hit) begin
      cpu_streak <= cpu_streak + ST_W'(1);
    end
  end

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_rr
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rr_last[l] <= CH_W'(NUM_CH - 1);
      end else if (dma_fire && win_is_rr && win_lvl == LVL_W'(l)) begin
        rr_last[l] <= win_idx;
      end
    end
  end

  assign grant_cpu = grant_cpu_q;
  assign grant_ch  = grant_ch_q;
  assign busy      = busy_q;
endmodule

// File: rtl/dma_arb_checker.sv
module dma_arb_checker #(
  parameter int NUM_CH = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic [NUM_CH-1:0] ch_req,
  input logic              xfer_done,
  input logic              grant_cpu,
  input logic [NUM_CH-1:0] grant_ch,
  input logic              busy,
  input logic              arb_open,
  input logic              dma_fire,
  input logic              cpu_quota_hit
);
  a_r1_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grant_cpu, grant_ch}));

  a_r2_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !xfer_done |=> $stable(grant_cpu) && $stable(grant_ch));

  a_r3_cpu_wins: assert property (@(posedge clk) disable iff (!rst_n)
    arb_open && cpu_req && !cpu_quota_hit |=> grant_cpu);

  a_r4_quota_forces_dma: assert property (@(posedge clk) disable iff (!rst_n)
    arb_open && cpu_quota_hit && (ch_req != '0) |=> !grant_cpu && (grant_ch != '0));

  a_r5_grant_was_requested: assert property (@(posedge clk) disable iff (!rst_n)
    dma_fire |=> (grant_ch & $past(ch_req)) != '0);

  a_r12_busy_matches_grant: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (grant_cpu || (grant_ch != '0)));
endmodule

bind dma_bus_arbiter dma_arb_checker #(.NUM_CH(NUM_CH)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_req      (cpu_req),
  .ch_req       (ch_req),
  .xfer_done    (xfer_done),
  .grant_cpu    (grant_cpu),
  .grant_ch     (grant_ch),
  .busy         (busy),
  .arb_open     (arb_open),
  .dma_fire     (dma_fire),
  .cpu_quota_hit(cpu_quota_hit)
);

// File: tb/dma_bus_arbiter_tb_top.sv
module dma_bus_arbiter_tb_top;
  localparam int N = 24;
  localparam int BASE = 4;
  localparam int QUOTA = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fair_en = 1'b0;
  logic          cpu_req = 1'b0;
  logic [N-1:0]  ch_req = '0;
  logic [3*N-1:0] ch_level;
  logic [N-1:0]  ch_rr_en = '0;
  logic          xfer_done = 1'b0;
  logic          grant_cpu;
  logic [N-1:0]  grant_ch;
  logic          busy;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dma_bus_arbiter #(.NUM_CH(N), .BASE_CREDIT(BASE), .CPU_MAX(QUOTA)) dut_i (
    .clk(clk), .rst_n(rst_n), .fair_en(fair_en), .cpu_req(cpu_req),
    .ch_req(ch_req), .ch_level(ch_level), .ch_rr_en(ch_rr_en),
    .xfer_done(xfer_done), .grant_cpu(grant_cpu), .grant_ch(grant_ch), .busy(busy)
  );

  // Channel c sits at level c mod 8.
  initial begin
    for (int c = 0; c < N; c++) ch_level[3*c +: 3] = 3'(c % 8);
  end

  // {cpu_req, ch_req, expected grant_cpu, expected grant_ch}; fair off, all head-of-line.
  localparam int VW = 2 + 2 * N;
  localparam logic [VW-1:0] VEC [9] = '{
    {1'b0, 24'h000020, 1'b0, 24'h000020},  // R5 lone L5
    {1'b1, 24'h000020, 1'b1, 24'h000000},  // R3 cpu beats dma
    {1'b0, 24'h000088, 1'b0, 24'h000008},  // R5 L3 over L7
    {1'b0, 24'h000410, 1'b0, 24'h000400},  // R5 L2 over L4
    {1'b0, 24'h010204, 1'b0, 24'h010000},  // R5 L0 over L1,L2
    {1'b0, 24'h000101, 1'b0, 24'h000001},  // R10 lowest index at L0
    {1'b0, 24'h808000, 1'b0, 24'h008000},  // R10 lowest index at L7
    {1'b1, 24'h000000, 1'b1, 24'h000000},  // R3 cpu alone
    {1'b0, 24'h000000, 1'b0, 24'h000000}   // R2 nothing requested
  };

  task automatic check(input string req, input logic exp_cpu, input logic [N-1:0] exp_ch);
    checks++;
    if (grant_cpu !== exp_cpu || grant_ch !== exp_ch) begin
      errors++;
      $display("FAIL %s: got cpu=%0b ch=%h, expected cpu=%0b ch=%h",
               req, grant_cpu, grant_ch, exp_cpu, exp_ch);
    end
  endtask

  // One arbitration point: inputs set, transaction end pulsed, sampled after the edge.
  task automatic run_txn(input logic c, input logic [N-1:0] r);
    @(negedge clk);
    cpu_req = c;
    ch_req = r;
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
  endtask

  function automatic logic [N-1:0] bit_of(input int i);
    return N'(1) << i;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cr2, cr3;
    logic [N-1:0] exp;
    string tag;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 reset no grant", 1'b0, '0);
    checks++;
    if (busy !== 1'b0) begin
      errors++;
      $display("FAIL R12 busy: got %0b expected 0", busy);
    end

    for (int v = 0; v < 9; v++) begin
      run_txn(VEC[v][VW-1], VEC[v][VW-2 -: N]);
      check("R5/R3/R10 vector", VEC[v][N], VEC[v][N-1:0]);
    end

    // R2 / R11: grant held, urgent request waits for the boundary.
    run_txn(1'b0, bit_of(5));
    check("R11 setup", 1'b0, bit_of(5));
    @(negedge clk);
    ch_req = bit_of(5) | bit_of(0);
    cpu_req = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 no preempt mid-transaction", 1'b0, bit_of(5));
    run_txn(1'b0, bit_of(5) | bit_of(0));
    check("R11 preempt at boundary", 1'b0, bit_of(0));

    // R4: CPU quota with channel 5 waiting.
    for (int k = 0; k < QUOTA; k++) begin
      run_txn(1'b1, bit_of(5));
      check("R3 cpu within quota", 1'b1, '0);
    end
    run_txn(1'b1, bit_of(5));
    check("R4 quota forces dma", 1'b0, bit_of(5));
    run_txn(1'b1, bit_of(5));
    check("R4 count cleared by dma grant", 1'b1, '0);

    // R9: round-robin among L2 channels 2, 10, 18.
    ch_rr_en = bit_of(2) | bit_of(10) | bit_of(18);
    run_txn(1'b0, bit_of(2) | bit_of(10) | bit_of(18));
    check("R9 rr first from reset pointer", 1'b0, bit_of(2));
    run_txn(1'b0, bit_of(2) | bit_of(10) | bit_of(18));
    check("R9 rr next", 1'b0, bit_of(10));
    run_txn(1'b0, bit_of(2) | bit_of(10) | bit_of(18));
    check("R9 rr next", 1'b0, bit_of(18));
    run_txn(1'b0, bit_of(2) | bit_of(10) | bit_of(18));
    check("R9 rr wrap", 1'b0, bit_of(2));
    // R10: channel 10 made head-of-line.
    ch_rr_en = bit_of(2) | bit_of(18);
    run_txn(1'b0, bit_of(2) | bit_of(10) | bit_of(18));
    check("R10 head-of-line wins", 1'b0, bit_of(10));
    run_txn(1'b0, bit_of(2) | bit_of(10) | bit_of(18));
    check("R10 head-of-line again", 1'b0, bit_of(10));
    run_txn(1'b0, bit_of(2) | bit_of(18));
    check("R9 rr resumes after pointer", 1'b0, bit_of(18));
    ch_rr_en = '0;

    // R7 / R8: levels 2 and 3 contend with fairness on. Weights 4 and 2.
    fair_en = 1'b1;
    cr2 = BASE;
    cr3 = BASE >> 1;
    for (int s = 0; s < 12; s++) begin
      tag = "R7 credit order";
      if (cr2 > 0) begin
        exp = bit_of(2); cr2--;
      end else if (cr3 > 0) begin
        exp = bit_of(3); cr3--;
      end else begin
        tag = "R8 refill"; exp = bit_of(2); cr2 = BASE - 1; cr3 = BASE >> 1;
      end
      run_txn(1'b0, bit_of(2) | bit_of(3));
      check(tag, 1'b0, exp);
    end
    // R6: level 1 wins regardless, consumes nothing.
    run_txn(1'b0, bit_of(1) | bit_of(2) | bit_of(3));
    check("R6 level 1 over fair levels", 1'b0, bit_of(1));
    run_txn(1'b0, bit_of(1) | bit_of(2) | bit_of(3));
    check("R6 level 1 again", 1'b0, bit_of(1));
    for (int s = 0; s < 4; s++) begin
      tag = "R6 credits untouched by level 1";
      if (cr2 > 0) begin
        exp = bit_of(2); cr2--;
      end else if (cr3 > 0) begin
        exp = bit_of(3); cr3--;
      end else begin
        tag = "R8 refill"; exp = bit_of(2); cr2 = BASE - 1; cr3 = BASE >> 1;
      end
      run_txn(1'b0, bit_of(2) | bit_of(3));
      check(tag, 1'b0, exp);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule